// File: doc/BRIEF.md
# Converter Serial Result Port

This block sends each 16-bit conversion result out on one serial data line, most significant bit first. A small built-in conversion stub provides the timing: a start pulse latches the sample presented at the input and holds `busy` high for a fixed number of cycles. The result then becomes available. Static configuration inputs set the output coding, the clocking role, the frame-pulse polarity, the serial clock polarity, a clock divider and the read timing.

As clock master, the port makes its own serial clock and a frame pulse that covers exactly the sixteen bit periods of a word. It sends either the previous result, at the moment a conversion starts, or the new result, as soon as the conversion ends. As clock slave, the result is loaded when the conversion ends and is shifted by an external serial clock. Bits taken in on the chain input follow the result bits on the output, so several converters can share one data line.

All timing runs on the system clock `clk`. The external serial clock is resynchronised and edge-detected, so it must be several system cycles per half period.

Top module: `adc_serial_port`

## Requirements
- R1: With `coding_bin` high, the word sent is the result unchanged. With it low, bit 15 of the result is inverted, which gives two's complement coding.
- R2: In master mode, a frame sends 16 bits, MSB first. Data changes only when the effective clock (`sclk_out` XOR `sclk_inv`) falls. Each bit is valid while the effective clock is high.
- R3: The frame pulse `sync_out` is active high when `sync_act_low` is 0 and active low when it is 1. In master mode it is active for exactly 16 bit periods per frame.
- R4: `sclk_inv` inverts the serial clock in both modes. In master mode `sclk_out` rests at the level of `sclk_inv` while no frame is active. In slave mode the effective clock is `sclk_in` XOR `sclk_inv`.
- R5: In master mode with read-after-conversion (`read_during` = 0), `div_sel` values 0, 1, 2 and 3 give bit periods of 2, 4, 8 and 16 system cycles. The effective clock is low for the first half of each bit period and high for the second half.
- R6: In master read-during mode, and in slave mode, `div_sel` has no effect. The master bit period is then 2 cycles.
- R7: In master mode with `read_during` = 1, an accepted start pulse begins a frame at the same clock edge. That frame sends the result of the previous conversion. The first such frame after reset sends a result of zero.
- R8: In master mode with `read_during` = 0, a frame begins at the clock edge where `busy` falls. That frame sends the result just converted.
- R9: An accepted start pulse makes `busy` high for exactly CONV_CYCLES cycles. A start pulse that arrives while `busy` is high is ignored, and the sample presented with it is not converted.
- R10: In slave mode, `sync_out` stays inactive and `sclk_out` is held at 0. The result is loaded when the conversion ends, and `read_during` has no effect.
- R11: In slave mode, `sdin` is sampled on each rising effective clock edge and shifted in behind the result. The level sampled at rise k appears on `sdout` from rise k+16.
- R12: After reset, `busy` is 0, `sdout` is 0, `sync_out` is inactive and `sclk_out` is at its idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion start pulse |
| sample_in | input | 16 | Value captured as the conversion result |
| coding_bin | input | 1 | 1: straight binary, 0: two's complement |
| clk_ext | input | 1 | 0: master (internal clock), 1: slave (external clock) |
| sync_act_low | input | 1 | Frame pulse polarity, 1 selects active low |
| sclk_inv | input | 1 | Serial clock inversion |
| div_sel | input | 2 | Master clock divider code |
| read_during | input | 1 | Master read timing, 1 = during conversion |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sdin | input | 1 | Daisy-chain serial input (slave mode) |
| busy | output | 1 | Conversion in progress |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| sync_out | output | 1 | Frame pulse (master mode) |
| sdout | output | 1 | Serial data output |

## Verification
The embedded assertions check three things on every cycle: the frame pulse length for the selected divider, that data changes only on a falling effective clock edge, and that the clock rests at its idle level outside a frame. They also check that no frame pulse appears in slave mode, and that a read-during start opens a frame on the next cycle. Only the bench scenarios can show the values that are actually sent. These include the coding of each word and the previous result sent in read-during mode, starting from zero after reset. They also include the rejection of a start pulse while busy and the sixteen-period delay of chained bits in slave mode.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start,
  input  logic [W-1:0] sample_in,
  input  logic         coding_bin,
  input  logic         clk_ext,
  input  logic         sync_act_low,
  input  logic         sclk_inv,
  input  logic [1:0]   div_sel,
  input  logic         read_during,
  input  logic         sclk_in,
  input  logic         sdin,
  output logic         busy,
  output logic         sclk_out,
  output logic         sync_out,
  output logic         sdout
);

  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int BW = $clog2(W);

  logic          busy_q;
  logic [CW-1:0] conv_cnt;
  logic [W-1:0]  pend_q, last_q, sh_q;
  logic          m_act, m_ph;
  logic [3:0]    hcnt;
  logic [BW-1:0] bcnt;
  logic [2:0]    s_pipe;
  logic          samp_q;

  wire master   = ~clk_ext;
  wire start_ok = conv_start & ~busy_q;
  wire conv_end = busy_q & (conv_cnt == '0);

  wire [1:0]   div_eff = (master & ~read_during) ? div_sel : 2'd0;
  wire [3:0]   hper    = 4'd1 << div_eff;
  wire [W-1:0] src     = (master & read_during) ? last_q : pend_q;
  wire [W-1:0] coded   = coding_bin ? src : {~src[W-1], src[W-2:0]};

  wire m_go   = master & ~m_act & (read_during ? start_ok : conv_end);
  wire s_load = ~master & conv_end;
  wire m_tick = m_act & (hcnt == hper - 4'd1);
  wire m_fall = m_tick & m_ph;
  wire s_rise = s_pipe[1] & ~s_pipe[2];
  wire s_fall = ~s_pipe[1] & s_pipe[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      conv_cnt <= '0;
      pend_q   <= '0;
      last_q   <= '0;
    end else if (start_ok) begin
      busy_q   <= 1'b1;
      conv_cnt <= CW'(CONV_CYCLES - 1);
      pend_q   <= sample_in;
    end else if (busy_q) begin
      if (conv_cnt == '0) begin
        busy_q <= 1'b0;
        last_q <= pend_q;
      end else begin
        conv_cnt <= conv_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 1'b0;
      m_ph  <= 1'b0;
      hcnt  <= '0;
      bcnt  <= '0;
    end else if (m_go) begin
      m_act <= 1'b1;
      m_ph  <= 1'b0;
      hcnt  <= '0;
      bcnt  <= '0;
    end else if (m_act) begin
      if (m_tick) begin
        hcnt <= '0;
        m_ph <= ~m_ph;
        if (m_ph) begin
          if (bcnt == BW'(W - 1)) m_act <= 1'b0;
          else                    bcnt  <= bcnt + 1'b1;
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_pipe <= '0;
      samp_q <= 1'b0;
    end else begin
      s_pipe <= {s_pipe[1:0], sclk_in ^ sclk_inv};
      if (~master & s_rise) samp_q <= sdin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sh_q <= '0;
    else if (m_go | s_load)    sh_q <= coded;
    else if (m_fall)           sh_q <= {sh_q[W-2:0], 1'b0};
    else if (~master & s_fall) sh_q <= {sh_q[W-2:0], samp_q};
  end

  assign busy     = busy_q;
  assign sdout    = sh_q[W-1];
  assign sync_out = (master & m_act) ^ sync_act_low;
  assign sclk_out = master ? ((m_act & m_ph) ^ sclk_inv) : 1'b0;

  wire        sync_on = sync_out ^ sync_act_low;
  wire        eff_clk = sclk_out ^ sclk_inv;
  logic [11:0] sync_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sync_len <= '0;
    else if (sync_on) sync_len <= sync_len + 1'b1;
    else              sync_len <= '0;
  end

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_on && $past(sync_on)) |-> (sync_len == (12'(2 * W) << div_eff))); // R3

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && sync_on && $past(sync_on) && sdout != $past(sdout))
      |-> ($past(eff_clk) && !eff_clk)); // R2

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !sync_on) |-> (sclk_out == sclk_inv)); // R4

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ext |-> (!sync_on && !sclk_out)); // R10

  AST_DURING_START: assert property (@(posedge clk) disable iff (!rst_n)
    (master && read_during && conv_start && !busy && !sync_on) |=> sync_on); // R7

endmodule

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int C = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_start = 0, coding_bin = 1, clk_ext = 0, sync_act_low = 0;
  logic sclk_inv = 0, read_during = 0, sclk_in = 0, sdin = 0;
  logic [1:0] div_sel = 0;
  logic [15:0] sample_in = 0;
  logic busy, sclk_out, sync_out, sdout;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port #(.W(16), .CONV_CYCLES(C)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .sample_in(sample_in),
    .coding_bin(coding_bin), .clk_ext(clk_ext), .sync_act_low(sync_act_low),
    .sclk_inv(sclk_inv), .div_sel(div_sel), .read_during(read_during),
    .sclk_in(sclk_in), .sdin(sdin), .busy(busy), .sclk_out(sclk_out),
    .sync_out(sync_out), .sdout(sdout));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [15:0] v, input bit cb);
    return cb ? v : (v ^ 16'h8000);
  endfunction

  task automatic grab(input int half, output logic [15:0] got, output int serr, output int cerr);
    got = 0; serr = 0; cerr = 0;
    for (int c = 0; c < 32 * half; c++) begin
      conv_start = 0;
      if ((sync_out ^ sync_act_low) !== 1'b1) serr++;
      if ((sclk_out ^ sclk_inv) !== ((c % (2 * half)) >= half)) cerr++;
      if ((c % (2 * half)) == half) got[15 - c / (2 * half)] = sdout;
      @(negedge clk);
    end
  endtask

  task automatic t_master(input logic [15:0] samp, input bit during, input logic [1:0] dv,
                          input bit cb, input bit inv, input bit pol,
                          input logic [15:0] exp, input string tag);
    logic [15:0] got; int serr, cerr, half;
    @(negedge clk);
    clk_ext = 0; read_during = during; div_sel = dv; coding_bin = cb;
    sclk_inv = inv; sync_act_low = pol;
    repeat (4) @(negedge clk);
    sample_in = samp; conv_start = 1;
    @(posedge clk);
    @(negedge clk); conv_start = 0;
    if (!during) begin
      repeat (C) @(posedge clk);
      @(negedge clk);
      chk(busy == 0, {tag, " R8 busy low at frame start"}, busy, 0);
    end
    half = during ? 1 : (1 << dv);
    grab(half, got, serr, cerr);
    chk(got == exp, {tag, " R1 R2 R7 R8 word"}, got, exp);
    chk(serr == 0, {tag, " R3 sync window"}, serr, 0);
    chk(cerr == 0, {tag, " R4 R5 R6 sclk shape"}, cerr, 0);
    chk(sync_out == pol && sclk_out == inv, {tag, " R3 R4 idle after frame"},
        {sync_out, sclk_out}, {pol, inv});
    wait (!busy);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_busy();
    logic [15:0] got; int serr, cerr, berr;
    @(negedge clk);
    clk_ext = 0; read_during = 0; div_sel = 0; coding_bin = 1; sclk_inv = 0; sync_act_low = 0;
    repeat (2) @(negedge clk);
    sample_in = 16'h5A0F; conv_start = 1;
    @(posedge clk);
    @(negedge clk); conv_start = 0;
    berr = 0;
    for (int c = 0; c < C; c++) begin
      if (busy !== 1'b1) berr++;
      if (c == 5) begin sample_in = 16'hFFFF; conv_start = 1; end
      if (c == 6) conv_start = 0;
      @(negedge clk);
    end
    chk(berr == 0, "R9 busy held for CONV_CYCLES", berr, 0);
    chk(busy == 0, "R9 busy falls after CONV_CYCLES", busy, 0);
    grab(1, got, serr, cerr);
    chk(got == 16'h5A0F, "R9 start while busy ignored", got, 16'h5A0F);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_slave(input logic [15:0] samp, input bit cb, input bit inv,
                         input logic [15:0] din, input string tag);
    logic [31:0] got, exp; int perr;
    @(negedge clk);
    clk_ext = 1; coding_bin = cb; sclk_inv = inv; sclk_in = inv; sdin = 0;
    read_during = 1; div_sel = 3; sync_act_low = 0;
    repeat (10) @(negedge clk);
    sample_in = samp; conv_start = 1;
    @(posedge clk);
    @(negedge clk); conv_start = 0;
    repeat (C + 4) @(negedge clk);
    got = 0; perr = 0;
    for (int k = 0; k < 32; k++) begin
      sclk_in = ~inv;
      sdin = (k < 16) ? din[15 - k] : 1'b0;
      repeat (6) @(negedge clk);
      got[31 - k] = sdout;
      if (sync_out !== 1'b0 || sclk_out !== 1'b0) perr++;
      sclk_in = inv;
      repeat (6) @(negedge clk);
    end
    exp = {enc(samp, cb), din};
    chk(got == exp, {tag, " R1 R4 R11 slave stream"}, got, exp);
    chk(perr == 0, {tag, " R10 slave pins quiet"}, perr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && sdout == 0, "R12 reset busy/sdout", {busy, sdout}, 0);
    chk(sync_out == 0 && sclk_out == 0, "R12 reset sync/sclk", {sync_out, sclk_out}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && sdout == 0, "R12 after release", {busy, sdout}, 0);
    t_master(16'h1234, 1, 2'd3, 1, 0, 0, 16'h0000, "during-first");
    t_master(16'hABCD, 1, 2'd2, 1, 0, 0, 16'h1234, "during-prev");
    t_master(16'h00F0, 0, 2'd0, 0, 0, 0, 16'h80F0, "after-div0");
    t_master(16'hC3A5, 0, 2'd2, 1, 1, 1, 16'hC3A5, "after-div2-inv");
    t_master(16'h7001, 0, 2'd3, 0, 0, 1, 16'hF001, "after-div3");
    t_busy();
    t_slave(16'h9C31, 1, 0, 16'hB2E7, "slave");
    t_slave(16'h0123, 0, 1, 16'h4F81, "slave-inv");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule